// File: doc/BRIEF.md
# E1 Channel-Associated Signaling Inserter

This block rebuilds timeslot 16 of an outgoing E1 bit stream when channel-associated signaling is used. It counts bits, timeslots and frames of a 16-frame multiframe. The count runs freely from reset, and a rising edge on the multiframe sync input realigns it. In frame 0 the block writes the multiframe alignment nibble followed by four extra/alarm bits taken from a register input.

In frames 1 to 15 the timeslot 16 octet can come from two places. It can pass through from the main serial data. It can also be assembled from A/B/C/D nibbles that the block captures from a separate signaling serial input. That input is sampled on falling clock edges in fixed windows of each frame. Each frame's captured octet is committed to a per-frame store at the end of the frame. It is sent in timeslot 16 of the same frame number one multiframe later, so a transmitted octet never mixes old and new samples.

In common-channel mode timeslot 16 is never touched. Every output bit equals the main serial input delayed by one clock.

Top module: `e1_cas_sig_inserter`

## Requirements
- R1: While reset is asserted the output is 1. In the first cycle after reset release the position is bit 1 (the first bit) of timeslot 0 of frame 0, and counting runs freely from there.
- R2: Framing is 8 bits per timeslot, most significant bit first, 32 timeslots per frame and 16 frames per multiframe. Every bit outside timeslot 16 appears at the output one clock after it is presented at the main serial input.
- R3: When the sync input is sampled high at a clock edge after being sampled low at the previous edge, the cycle just sampled becomes bit 1 of timeslot 0 of frame 0, and counting continues from there.
- R4: When common-channel mode is off, the first four bits of timeslot 16 in frame 0 are transmitted as 0.
- R5: When common-channel mode is off, bits 5 to 8 of timeslot 16 in frame 0 carry the extra/alarm input, with bit 3 of that input sent first.
- R6: The signaling input is sampled on the falling clock edge during bit times 5 to 8 of the capture windows. In frame n (n = 1 to 14) the windows are timeslot n, which gives the upper nibble, and timeslot n+17, which gives the lower nibble. In frame 15 the only window is timeslot 15, which gives the upper nibble. The first sample of a window becomes the most significant bit of its nibble.
- R7: With source select set (1) and common-channel mode off, timeslot 16 of frame n (1 to 15) carries the octet {upper nibble, lower nibble} captured in frame n of the previous multiframe. The lower nibble of frame 15 is always 1111. Before any frame n has completed since reset, that frame sends 8'hFF.
- R8: A frame cut short by a sync realignment commits nothing, so its store keeps the octet from the last complete frame with that number.
- R9: With source select clear (0) and common-channel mode off, timeslot 16 of frames 1 to 15 is copied from the main serial input.
- R10: With common-channel mode set (1), every output bit, including all of frame 0's timeslot 16, is copied from the main serial input, whatever the source select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_i | input | 1 | Main serial data in |
| sig_i | input | 1 | Signaling serial data, sampled on falling edges |
| mf_sync_i | input | 1 | Multiframe sync; a rising edge sets frame 0 |
| sig_src_sel_i | input | 1 | 1: timeslot 16 from captured nibbles; 0: from ser_i |
| ccs_mode_i | input | 1 | 1: common-channel mode, timeslot 16 untouched |
| xa_bits_i | input | 4 | Extra/alarm bits for frame 0 timeslot 16 |
| ser_o | output | 1 | Serial data out with timeslot 16 rebuilt |

## Verification
The first pattern drives random bits on both serial inputs with signaling selected. It starts straight from reset, so the all-ones store is seen first and then packed octets one multiframe later. A second pattern drives the signaling input low only inside the capture windows and high everywhere else. Any window misplaced by one timeslot or bit then shows up as a 1 in an octet that should read 00 (0F in frame 15).

Sync edges are placed off the multiframe boundary, including one in the middle of a lower-nibble window. These separate a proper realignment from a late one, and show whether a cut-short frame leaks into its store. Common-channel mode and pass-through mode are each run with random data, showing that frame 0 insertion stops only in the first case.

// File: rtl/e1_cas_sig_inserter.sv
`timescale 1ns/1ps
module e1_cas_sig_inserter #(
  parameter int SLOT_BITS       = 8,
  parameter int SLOTS_PER_FRAME = 32,
  parameter int FRAMES_PER_MF   = 16,
  parameter int SIG_SLOT        = 16,
  parameter int NIB             = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ser_i,
  input  logic           sig_i,
  input  logic           mf_sync_i,
  input  logic           sig_src_sel_i,
  input  logic           ccs_mode_i,
  input  logic [NIB-1:0] xa_bits_i,
  output logic           ser_o
);
  localparam int BW        = $clog2(SLOT_BITS);
  localparam int TW        = $clog2(SLOTS_PER_FRAME);
  localparam int FW        = $clog2(FRAMES_PER_MF);
  localparam int LO_OFS    = SIG_SLOT + 1;
  localparam int CAP_START = SLOT_BITS - NIB;

  logic          sync_d_q, sync_rise;
  logic [BW-1:0] bit_q, bit_c;
  logic [TW-1:0] ts_q, ts_c;
  logic [FW-1:0] fr_q, fr_c;
  logic          last_bit, last_ts, last_fr;
  logic          sig_s_q;
  logic [NIB-1:0] hi_q, lo_q, hi_nx, lo_nx;
  logic          in_cap, cap_hi, cap_lo, commit, fr15;
  logic [SLOT_BITS-1:0] slot_q [FRAMES_PER_MF];
  logic [SLOT_BITS-1:0] tx_byte;
  logic          ins_bit, use_ins, ser_q;

  assign sync_rise = mf_sync_i & ~sync_d_q;
  assign bit_c     = sync_rise ? '0 : bit_q;
  assign ts_c      = sync_rise ? '0 : ts_q;
  assign fr_c      = sync_rise ? '0 : fr_q;
  assign last_bit  = bit_c == BW'(SLOT_BITS - 1);
  assign last_ts   = ts_c == TW'(SLOTS_PER_FRAME - 1);
  assign last_fr   = fr_c == FW'(FRAMES_PER_MF - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_d_q <= 1'b0;
      bit_q    <= '0;
      ts_q     <= '0;
      fr_q     <= '0;
    end else begin
      sync_d_q <= mf_sync_i;
      bit_q    <= last_bit ? '0 : bit_c + 1'b1;
      if (last_bit) begin
        ts_q <= last_ts ? '0 : ts_c + 1'b1;
        if (last_ts) fr_q <= last_fr ? '0 : fr_c + 1'b1;
        else         fr_q <= fr_c;
      end else begin
        ts_q <= ts_c;
        fr_q <= fr_c;
      end
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_s_q <= 1'b1;
    else         sig_s_q <= sig_i;
  end

  assign fr15   = last_fr;
  assign in_cap = (bit_c >= BW'(CAP_START)) && (fr_c != '0);
  assign cap_hi = in_cap && (int'(ts_c) == int'(fr_c));
  assign cap_lo = in_cap && (int'(ts_c) == int'(fr_c) + LO_OFS);
  assign hi_nx  = cap_hi ? {hi_q[NIB-2:0], sig_s_q} : hi_q;
  assign lo_nx  = cap_lo ? {lo_q[NIB-2:0], sig_s_q} : lo_q;
  assign commit = last_bit && last_ts && (fr_c != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '1;
      lo_q <= '1;
      for (int i = 0; i < FRAMES_PER_MF; i++) slot_q[i] <= '1;
    end else begin
      hi_q <= hi_nx;
      lo_q <= lo_nx;
      if (commit) slot_q[fr_c] <= {hi_nx, fr15 ? {NIB{1'b1}} : lo_nx};
    end
  end

  assign tx_byte = (fr_c == '0) ? {{NIB{1'b0}}, xa_bits_i} : slot_q[fr_c];
  assign ins_bit = tx_byte[BW'(SLOT_BITS - 1) - bit_c];
  assign use_ins = (ts_c == TW'(SIG_SLOT)) && !ccs_mode_i &&
                   ((fr_c == '0) || sig_src_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ser_q <= 1'b1;
    else         ser_q <= use_ins ? ins_bit : ser_i;
  end
  assign ser_o = ser_q;

  p_copy_outside_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_c != TW'(SIG_SLOT)) |=> (ser_o == $past(ser_i)));

  p_ccs_copy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccs_mode_i |=> (ser_o == $past(ser_i)));

  p_pass_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sig_src_sel_i && (fr_c != '0)) |=> (ser_o == $past(ser_i)));

  p_mfas_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ccs_mode_i && ts_c == TW'(SIG_SLOT) && fr_c == '0 && bit_c < BW'(NIB))
    |=> !ser_o);

  p_sync_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mf_sync_i) |=> (bit_q == BW'(1) && ts_q == '0 && fr_q == '0));
endmodule

// File: tb/e1_cas_sig_inserter_tb_top.sv
`timescale 1ns/1ps
module e1_cas_sig_inserter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_in = 1'b1, sig_in = 1'b1, msync = 1'b0, src_sel = 1'b0, ccs = 1'b0;
  logic [3:0] xa = 4'h0;
  logic ser_out;

  always #2 clk = ~clk;

  e1_cas_sig_inserter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser_in), .sig_i(sig_in),
    .mf_sync_i(msync), .sig_src_sel_i(src_sel), .ccs_mode_i(ccs),
    .xa_bits_i(xa), .ser_o(ser_out));

  bit    exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_fail = 0;

  int   m_bit = 1, m_ts = 0, m_fr = 0;
  logic [7:0] m_slot [16];
  logic [3:0] m_hi = 4'hF, m_lo = 4'hF;
  logic m_prev_sync = 1'b0;
  string phase = "R1";

  logic nx_src = 1'b1, nx_ccs = 1'b0;
  logic [3:0] nx_xa = 4'h5;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_out=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive_cycle(input logic s_sync, input int sig_mode);
    logic s_ser, s_sig, e, win;
    string t;
    @(posedge clk); #1;
    if (s_sync && !m_prev_sync) begin m_bit = 0; m_ts = 0; m_fr = 0; end
    m_prev_sync = s_sync;
    win = (m_bit >= 4) && (m_fr != 0) && ((m_ts == m_fr) || (m_ts == m_fr + 17));
    s_ser = 1'($urandom);
    s_sig = (sig_mode == 1) ? ~win : 1'($urandom);
    ser_in = s_ser; sig_in = s_sig; msync = s_sync;
    src_sel = nx_src; ccs = nx_ccs; xa = nx_xa;
    if (m_ts != 16)          begin e = s_ser; t = "R2"; end
    else if (nx_ccs)         begin e = s_ser; t = "R10"; end
    else if (m_fr == 0)      begin
      if (m_bit < 4) begin e = 1'b0; t = "R4"; end
      else begin e = nx_xa[7 - m_bit]; t = "R5"; end
    end
    else if (!nx_src)        begin e = s_ser; t = "R9"; end
    else                     begin e = m_slot[m_fr][7 - m_bit]; t = "R7"; end
    exp_q.push_back(e);
    tag_q.push_back({t, " [phase ", phase, "]"});
    if (win) begin
      if (m_ts == m_fr) m_hi = {m_hi[2:0], s_sig};
      else              m_lo = {m_lo[2:0], s_sig};
    end
    if (m_bit == 7 && m_ts == 31 && m_fr != 0)
      m_slot[m_fr] = {m_hi, (m_fr == 15) ? 4'hF : m_lo};
    m_bit++;
    if (m_bit == 8) begin
      m_bit = 0; m_ts++;
      if (m_ts == 32) begin m_ts = 0; m_fr = (m_fr + 1) % 16; end
    end
  endtask

  task automatic run(input int n, input int sig_mode);
    for (int i = 0; i < n; i++) drive_cycle(1'b0, sig_mode);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); #0.5;
      if (exp_q.size() > 0) check(ser_out, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
  end

  localparam int MF = 4096;

  initial begin
    for (int i = 0; i < 16; i++) m_slot[i] = 8'hFF;
    repeat (3) @(posedge clk); #0.5;
    check(ser_out, 1'b1, "R1 reset idle");
    @(posedge clk); #1;
    rst_n = 1'b1;
    src_sel = 1'b1;
    xa = 4'h5;
    // R1: free-running count from reset; first multiframe shows stored 8'hFF (R7)
    phase = "R1";
    run(MF, 0);
    // R3: realign at an arbitrary point, random signaling
    phase = "R3"; nx_xa = 4'hA;
    run(777, 0);
    drive_cycle(1'b1, 0); drive_cycle(1'b1, 0); drive_cycle(1'b1, 0);
    run(3 * MF, 0);
    // R6: signaling low only inside the capture windows
    phase = "R6"; nx_xa = 4'h3;
    run(2 * MF + 100, 0 + 1);
    // R8: sync edge in the middle of frame 5's lower-nibble window
    phase = "R8"; nx_xa = 4'h9;
    while (!(m_fr == 5 && m_ts == 22 && m_bit == 6)) drive_cycle(1'b0, 0);
    drive_cycle(1'b1, 0);
    run(2 * MF, 0);
    // R10: common-channel mode with both source selections
    phase = "R10"; nx_ccs = 1'b1;
    run(MF, 0);
    nx_src = 1'b0;
    run(MF / 2, 0);
    // R9: pass-through selection with alignment still inserted
    phase = "R9"; nx_ccs = 1'b0; nx_xa = 4'h6;
    run(MF + 50, 0);
    repeat (3) @(posedge clk);
    summary();
  end
endmodule